// File: doc/BRIEF.md
# Counted Transfer Sequencer

This block is the master-side control state machine of a byte-oriented serial bus controller. Software programs a byte count and writes a control word carrying enable, master, direction, repeat and stop/start requests. The sequencer then asks a byte-level bus engine to perform a start (address phase), individual byte sends or receives, and a stop. Each request is held until the engine reports completion along with an acknowledge flag. The sequencer tracks the number of bytes still to move, watches the fill levels of an external four-byte transmit and receive buffer, and raises ready flags and one-cycle access-ready and no-acknowledge pulses.

There are two ways a transfer can end. In counted mode the remaining count governs the transfer. When the count reaches zero, either a stop is issued or the sequencer reports access-ready and drops master mode, depending on the stop bit. In repeat mode the count is left untouched: the sequencer drains or fills the buffer and then signals ready. A pending stop in repeat mode is executed at once. While the bus is held, each pulse on the buffer-event input runs the sequencer again, so software can keep a long transfer going by refilling or draining the buffer.

Top module: `counted_xfer_seq`

## Requirements
- R1: The control register holds only the bits of mask 0xCF87 (bit 15 enable, 14 byte order, 11:8 kept, bit 10 master, bit 9 transmit, bit 8 ten-bit addressing, bit 7 kept, bit 2 repeat, bit 1 stop, bit 0 start). After reset the control word, the remaining count and every status output are zero, and no engine request is raised.
- R2: A start request (engine op code 0) is raised only when enable, master and start are all set and bit 8 is clear. The start bit reads back as zero once the request has been raised. The other op codes are 1 send, 2 receive and 3 stop.
- R3: If the start completes without acknowledge, a no-acknowledge pulse is raised, the stop bit is cleared, the bus stays free and the count is not loaded. If the start is acknowledged, the bus becomes busy and the remaining count is loaded from the programmed count.
- R4: In counted transmit mode, one send is issued per buffered byte while the count is nonzero, and each completed send pops one byte and decrements the count. When sending pauses, transmit-ready is set if bytes are still owed and cleared if the count is zero.
- R5: In counted receive mode, receives are issued while the count is nonzero and the buffer holds fewer than 4 bytes. Each completed receive pushes one byte and decrements the count. Receive-ready then shows whether the buffer holds any byte.
- R6: When the count reaches zero with the stop bit set, a stop is issued. Once the stop completes, the stop bit clears, the count reloads from the programmed count, the transmit buffer is flushed and the bus is released.
- R7: When the count reaches zero with the stop bit clear, a one-cycle access-ready pulse is raised and the master bit is cleared.
- R8: In repeat mode the count never changes. Transmit sends every buffered byte and then sets transmit-ready. Receive fills the buffer to 4 bytes and then sets receive-ready. A set stop bit issues a stop before any byte moves.
- R9: A send completed without acknowledge raises the no-acknowledge pulse, clears the stop bit and ends sending for that run. Transmit-ready is then cleared in counted mode and set in repeat mode. The count still decrements for that byte in counted mode.
- R10: With the legacy option on (the default), a control write with enable clear resets the sequencer: the bus is freed, both counts become zero and the ready flags clear.
- R11: A buffer-event pulse runs the sequencer again only while the bus is busy; at any other time it has no effect.
- R12: When a control write lands in the same cycle as the sequencer clearing the start, stop or master bit, the written value is kept except for the cleared bit, which reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| cnt_wr_i | input | 1 | Programmed count write strobe |
| cnt_wdata_i | input | CNT_W | Programmed count write data |
| tx_level_i | input | LVL_W | Bytes waiting in the transmit buffer |
| rx_level_i | input | LVL_W | Bytes held in the receive buffer |
| buf_evt_i | input | 1 | Buffer changed; run the sequencer again |
| eng_req_o | output | 1 | Request to the byte engine, held until done |
| eng_op_o | output | 2 | Requested operation: 0 start, 1 send, 2 receive, 3 stop |
| eng_done_i | input | 1 | Engine completed the requested operation |
| eng_ack_i | input | 1 | Acknowledge result of the completed operation |
| tx_pop_o | output | 1 | Remove one byte from the transmit buffer |
| rx_push_o | output | 1 | Store the received byte in the receive buffer |
| tx_flush_o | output | 1 | Empty the transmit buffer |
| ctrl_o | output | 16 | Current control word |
| count_o | output | CNT_W | Remaining byte count |
| bus_busy_o | output | 1 | Bus held by this master |
| tx_ready_o | output | 1 | Transmit-ready flag |
| rx_ready_o | output | 1 | Receive-ready flag |
| ardy_o | output | 1 | Access-ready pulse |
| nack_o | output | 1 | No-acknowledge pulse |

## Verification
A software write to the control word and the sequencer's own clearing of the stop bit can take effect on the same clock edge. The bench provokes this collision with a start that is not acknowledged. It watches for the engine's completion of the start phase and, in that very cycle, writes a control word with stop set. The stop bit must then read back as zero while the rest of the written word stands. The checker also requires that no pulse of access-ready or no-acknowledge is ever seen with the bit it clears still set.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_EVAL,
    ST_SEND,
    ST_RECV,
    ST_STOP
  } seq_state_e;

  localparam int CB_EN  = 15;
  localparam int CB_MST = 10;
  localparam int CB_TRX = 9;
  localparam int CB_XA  = 8;
  localparam int CB_RM  = 2;
  localparam int CB_STP = 1;
  localparam int CB_STT = 0;

  localparam logic [15:0] CTRL_KEEP = 16'hCF87;

  function automatic logic [15:0] ctrl_filter(input logic [15:0] w);
    return w & CTRL_KEEP;
  endfunction

  function automatic logic start_ok(input logic [15:0] c);
    return c[CB_EN] & c[CB_MST] & c[CB_STT] & ~c[CB_XA];
  endfunction

  function automatic logic [15:0] ctrl_clear(input logic [15:0] c,
                                             input logic kill_stt,
                                             input logic kill_stp,
                                             input logic kill_mst);
    logic [15:0] m;
    m = '0;
    m[CB_STT] = kill_stt;
    m[CB_STP] = kill_stp;
    m[CB_MST] = kill_mst;
    return c & ~m;
  endfunction

endpackage

// File: rtl/cts_ctrl_reg.sv
module cts_ctrl_reg
  import cts_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        clr_start,
  input  logic        clr_stop,
  input  logic        clr_master,
  output logic [15:0] ctrl_q
);

  logic [15:0] base;

  assign base = wr ? ctrl_filter(wdata) : ctrl_q;

  // Sequencer clears are applied on top of a same-cycle write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_clear(base, clr_start, clr_stop, clr_master);
  end

endmodule

// File: rtl/cts_count.sv
module cts_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             prog_wr,
  input  logic [CNT_W-1:0] prog_data,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] count_q
);

  logic [CNT_W-1:0] prog_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prog_q <= '0;
    else if (soft_clr) prog_q <= '0;
    else if (prog_wr)  prog_q <= prog_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (soft_clr) count_q <= '0;
    else if (load)     count_q <= prog_q;
    else if (dec)      count_q <= step_down(count_q);
  end

endmodule

// File: rtl/counted_xfer_seq.sv
module counted_xfer_seq
  import cts_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int BUF_DEPTH    = 4,
  parameter bit LEGACY_RESET = 1'b1,
  localparam int LVL_W       = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [15:0]      ctrl_wdata_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             buf_evt_i,
  output logic             eng_req_o,
  output logic [1:0]       eng_op_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic             tx_flush_o,
  output logic [15:0]      ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             bus_busy_o,
  output logic             tx_ready_o,
  output logic             rx_ready_o,
  output logic             ardy_o,
  output logic             nack_o
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(BUF_DEPTH);

  function automatic logic rx_room(input logic [LVL_W-1:0] lvl);
    return lvl < FULL_LVL;
  endfunction

  seq_state_e state_q, state_n;
  logic [15:0] ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, run_pend_q, txr_q, rxr_q, ardy_q, nack_q;

  // Named internal events
  logic launch_start, clr_stop, clr_master, cnt_load, cnt_dec;
  logic busy_set, busy_clr, ardy_n, nack_n, txr_n, rxr_n, run_take;
  logic pop, push, flush, soft_rst, cnt_nz;

  generate
    if (LEGACY_RESET) begin : g_legacy
      assign soft_rst = ctrl_wr_i & ~ctrl_wdata_i[CB_EN];
    end else begin : g_modern
      assign soft_rst = 1'b0;
    end
  endgenerate

  assign cnt_nz = (cnt_q != '0);

  cts_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctrl_wr_i),
    .wdata      (ctrl_wdata_i),
    .clr_start  (launch_start),
    .clr_stop   (clr_stop),
    .clr_master (clr_master),
    .ctrl_q     (ctrl_q)
  );

  cts_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_rst),
    .prog_wr   (cnt_wr_i),
    .prog_data (cnt_wdata_i),
    .load      (cnt_load),
    .dec       (cnt_dec),
    .count_q   (cnt_q)
  );

  always_comb begin
    logic fin;
    state_n      = state_q;
    launch_start = 1'b0;
    clr_stop     = 1'b0;
    clr_master   = 1'b0;
    cnt_load     = 1'b0;
    cnt_dec      = 1'b0;
    busy_set     = 1'b0;
    busy_clr     = 1'b0;
    ardy_n       = 1'b0;
    nack_n       = 1'b0;
    txr_n        = txr_q;
    rxr_n        = rxr_q;
    run_take     = 1'b0;
    pop          = 1'b0;
    push         = 1'b0;
    flush        = 1'b0;
    fin          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok(ctrl_q)) begin
          launch_start = 1'b1;
          state_n      = ST_START;
        end else if (busy_q && run_pend_q) begin
          run_take = 1'b1;
          state_n  = ST_EVAL;
        end
      end
      ST_START: begin
        if (eng_done_i) begin
          if (eng_ack_i) begin
            busy_set = 1'b1;
            cnt_load = 1'b1;
            state_n  = ST_EVAL;
          end else begin
            nack_n   = 1'b1;
            clr_stop = 1'b1;
            state_n  = ST_IDLE;
          end
        end
      end
      ST_EVAL: begin
        state_n = ST_IDLE;
        if (ctrl_q[CB_RM]) begin
          if (ctrl_q[CB_STP])            state_n = ST_STOP;
          else if (ctrl_q[CB_TRX]) begin
            if (tx_level_i != '0)        state_n = ST_SEND;
            else                         txr_n   = 1'b1;
          end else begin
            if (rx_room(rx_level_i))     state_n = ST_RECV;
            else                         rxr_n   = 1'b1;
          end
        end else if (ctrl_q[CB_TRX]) begin
          if (cnt_nz && tx_level_i != '0) state_n = ST_SEND;
          else begin
            txr_n = cnt_nz;
            fin   = ~cnt_nz;
          end
        end else begin
          if (cnt_nz && rx_room(rx_level_i)) state_n = ST_RECV;
          else begin
            rxr_n = (rx_level_i != '0);
            fin   = ~cnt_nz;
          end
        end
        if (fin) begin
          if (ctrl_q[CB_STP]) state_n = ST_STOP;
          else begin
            ardy_n     = 1'b1;
            clr_master = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (eng_done_i) begin
          pop     = 1'b1;
          cnt_dec = ~ctrl_q[CB_RM];
          if (eng_ack_i) state_n = ST_EVAL;
          else begin
            nack_n   = 1'b1;
            clr_stop = 1'b1;
            txr_n    = ctrl_q[CB_RM];
            state_n  = ST_IDLE;
          end
        end
      end
      ST_RECV: begin
        if (eng_done_i) begin
          push    = 1'b1;
          cnt_dec = ~ctrl_q[CB_RM];
          state_n = ST_EVAL;
        end
      end
      ST_STOP: begin
        if (eng_done_i) begin
          flush    = 1'b1;
          clr_stop = 1'b1;
          cnt_load = 1'b1;
          busy_clr = 1'b1;
          state_n  = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      busy_q     <= 1'b0;
      run_pend_q <= 1'b0;
      txr_q      <= 1'b0;
      rxr_q      <= 1'b0;
      ardy_q     <= 1'b0;
      nack_q     <= 1'b0;
    end else if (soft_rst) begin
      state_q    <= ST_IDLE;
      busy_q     <= 1'b0;
      run_pend_q <= 1'b0;
      txr_q      <= 1'b0;
      rxr_q      <= 1'b0;
      ardy_q     <= 1'b0;
      nack_q     <= 1'b0;
    end else begin
      state_q    <= state_n;
      busy_q     <= busy_set | (busy_q & ~busy_clr);
      run_pend_q <= (buf_evt_i & busy_q) | (run_pend_q & busy_q & ~run_take);
      txr_q      <= txr_n;
      rxr_q      <= rxr_n;
      ardy_q     <= ardy_n;
      nack_q     <= nack_n;
    end
  end

  always_comb begin
    eng_req_o = 1'b1;
    eng_op_o  = OP_START;
    unique case (state_q)
      ST_START: eng_op_o = OP_START;
      ST_SEND:  eng_op_o = OP_SEND;
      ST_RECV:  eng_op_o = OP_RECV;
      ST_STOP:  eng_op_o = OP_STOP;
      default:  eng_req_o = 1'b0;
    endcase
  end

  assign tx_pop_o   = pop;
  assign rx_push_o  = push;
  assign tx_flush_o = flush;
  assign ctrl_o     = ctrl_q;
  assign count_o    = cnt_q;
  assign bus_busy_o = busy_q;
  assign tx_ready_o = txr_q;
  assign rx_ready_o = rxr_q;
  assign ardy_o     = ardy_q;
  assign nack_o     = nack_q;

endmodule

// File: rtl/cts_checker.sv
module cts_checker
  import cts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_req_o,
  input logic [1:0]       eng_op_o,
  input logic             eng_done_i,
  input logic [15:0]      ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             bus_busy_o,
  input logic             ardy_o,
  input logic             nack_o,
  input logic             tx_pop_o,
  input logic             rx_push_o,
  input logic             tx_flush_o,
  input logic             launch_start,
  input logic             soft_rst,
  input logic             cnt_dec,
  input logic             cnt_load
);

  // R2
  launch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_start && !soft_rst) |=> (eng_req_o && eng_op_o == OP_START));

  // R4
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> (count_o != '0));

  // R4
  buf_ops_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_pop_o, rx_push_o, tx_flush_o}));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && eng_op_o == OP_STOP && eng_done_i) |=> (!bus_busy_o && !ctrl_o[CB_STP]));

  // R7
  ardy_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_o |-> !ctrl_o[CB_MST]);

  // R9
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> !ctrl_o[CB_STP]);

  // R8
  rpt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[CB_RM] && $past(ctrl_o[CB_RM]) && bus_busy_o && $past(bus_busy_o)
     && !$past(cnt_load)) |-> $stable(count_o));

endmodule

bind counted_xfer_seq cts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_req_o    (eng_req_o),
  .eng_op_o     (eng_op_o),
  .eng_done_i   (eng_done_i),
  .ctrl_o       (ctrl_o),
  .count_o      (count_o),
  .bus_busy_o   (bus_busy_o),
  .ardy_o       (ardy_o),
  .nack_o       (nack_o),
  .tx_pop_o     (tx_pop_o),
  .rx_push_o    (rx_push_o),
  .tx_flush_o   (tx_flush_o),
  .launch_start (launch_start),
  .soft_rst     (soft_rst),
  .cnt_dec      (cnt_dec),
  .cnt_load     (cnt_load)
);

// File: tb/counted_xfer_seq_tb_top.sv
module counted_xfer_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int LVL_W = 3;
  localparam int MAX_CYC = 100000;
  localparam int SETTLE = 40;

  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200;
  localparam logic [15:0] RM = 16'h0004, STP = 16'h0002, STT = 16'h0001;

  typedef struct packed {
    logic       trx, rm, stp;
    logic [7:0] cnt;
    logic [2:0] tx, rxp;
    logic [3:0] nk;
    logic [7:0] e_cnt;
    logic [2:0] e_sent, e_recv;
    logic [1:0] e_stops;
    logic       e_ardy, e_nack, e_stp, e_mst, e_busy, e_txr, e_rxr;
    logic [2:0] e_txl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b1,8'd3,3'd4,3'd0,4'd0,  8'd3,3'd3,3'd0,2'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0},
    '{1'b1,1'b0,1'b0,8'd2,3'd2,3'd0,4'd0,  8'd0,3'd2,3'd0,2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0},
    '{1'b1,1'b0,1'b1,8'd5,3'd3,3'd0,4'd0,  8'd2,3'd3,3'd0,2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 3'd0},
    '{1'b0,1'b0,1'b1,8'd3,3'd0,3'd0,4'd0,  8'd3,3'd0,3'd3,2'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 3'd0},
    '{1'b0,1'b0,1'b0,8'd6,3'd0,3'd1,4'd0,  8'd3,3'd0,3'd3,2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 3'd0},
    '{1'b0,1'b0,1'b0,8'd0,3'd0,3'd0,4'd0,  8'd0,3'd0,3'd0,2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0},
    '{1'b1,1'b1,1'b0,8'd2,3'd4,3'd0,4'd0,  8'd2,3'd4,3'd0,2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd0},
    '{1'b0,1'b1,1'b0,8'd1,3'd0,3'd2,4'd0,  8'd1,3'd0,3'd2,2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 3'd0},
    '{1'b1,1'b1,1'b1,8'd2,3'd3,3'd0,4'd0,  8'd2,3'd0,3'd0,2'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0},
    '{1'b1,1'b0,1'b1,8'd4,3'd4,3'd0,4'd2,  8'd2,3'd2,3'd0,2'd0, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 3'd2},
    '{1'b1,1'b0,1'b1,8'd3,3'd3,3'd0,4'd15, 8'd0,3'd0,3'd0,2'd0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd3},
    '{1'b1,1'b1,1'b0,8'd2,3'd3,3'd0,4'd1,  8'd2,3'd1,3'd0,2'd0, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd2},
    '{1'b0,1'b0,1'b0,8'd2,3'd0,3'd3,4'd0,  8'd1,3'd0,3'd1,2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 1'b0, cnt_wr = 1'b0, buf_evt = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic [LVL_W-1:0] tx_add = '0, rx_add = '0;
  logic buf_clr = 1'b0;
  logic eng_done = 1'b0, eng_ack = 1'b0;
  logic eng_req, tx_pop, rx_push, tx_flush, bus_busy, tx_ready, rx_ready, ardy, nack;
  logic [1:0] eng_op;
  logic [15:0] ctrl_rd;
  logic [CNT_W-1:0] count_rd;

  int checks = 0, errors = 0, cyc = 0;
  int n_pop = 0, n_push = 0, n_stop = 0, n_ardy = 0, n_nack = 0, n_start = 0;
  int nack_byte = 0, send_idx = 0;
  bit addr_nack = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  counted_xfer_seq #(.CNT_W(CNT_W), .BUF_DEPTH(4), .LEGACY_RESET(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .tx_level_i(tx_level), .rx_level_i(rx_level), .buf_evt_i(buf_evt),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_done_i(eng_done), .eng_ack_i(eng_ack),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .tx_flush_o(tx_flush),
    .ctrl_o(ctrl_rd), .count_o(count_rd), .bus_busy_o(bus_busy),
    .tx_ready_o(tx_ready), .rx_ready_o(rx_ready), .ardy_o(ardy), .nack_o(nack)
  );

  // Buffer model
  always @(posedge clk) begin
    if (buf_clr) begin
      tx_level <= '0;
      rx_level <= '0;
    end else begin
      tx_level <= tx_flush ? '0 : tx_level - LVL_W'(tx_pop) + tx_add;
      rx_level <= rx_level + LVL_W'(rx_push) + rx_add;
    end
  end

  // Byte engine model: answers one cycle after a request appears
  always @(posedge clk) begin
    #1;
    if (eng_done) begin
      eng_done = 1'b0;
    end else if (eng_req) begin
      eng_done = 1'b1;
      case (eng_op)
        2'd0: begin send_idx = 0; eng_ack = !addr_nack; end
        2'd1: begin send_idx++; eng_ack = (send_idx != nack_byte); end
        default: eng_ack = 1'b1;
      endcase
    end
  end

  // Event counters sampled away from the edge
  always @(negedge clk) begin
    cyc++;
    if (tx_pop) n_pop++;
    if (rx_push) n_push++;
    if (ardy) n_ardy++;
    if (nack) n_nack++;
    if (eng_req && eng_done && eng_op == 2'd3) n_stop++;
    if (eng_req && eng_done && eng_op == 2'd0) n_start++;
    if (cyc > MAX_CYC && !done_flag) begin
      done_flag = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected <= %0d", cyc, MAX_CYC);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_cnt(input int v);
    cnt_wr = 1'b1; cnt_wdata = CNT_W'(v);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic add_bytes(input int t, input int r, input bit evt);
    tx_add = LVL_W'(t); rx_add = LVL_W'(r); buf_evt = evt;
    @(negedge clk);
    tx_add = '0; rx_add = '0; buf_evt = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_pop = 0; n_push = 0; n_stop = 0; n_ardy = 0; n_nack = 0; n_start = 0;
  endtask

  // Legacy reset, empty buffers, program and launch
  task automatic setup(input logic [15:0] mode, input int cnt, input int t, input int r,
                       input int nk);
    wr_ctrl(16'h0000);
    buf_clr = 1'b1;
    @(negedge clk);
    buf_clr = 1'b0;
    wr_cnt(cnt);
    add_bytes(t, r, 1'b0);
    nack_byte = (nk == 15) ? 0 : nk;
    addr_nack = (nk == 15);
    clear_counts();
    wr_ctrl(EN | MST | STT | mode);
    wait_cyc(SETTLE);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 ctrl after reset", ctrl_rd, 0);
    check("R1 count after reset", count_rd, 0);
    check("R1 no request after reset", eng_req, 0);
    check("R1 status after reset", {bus_busy, tx_ready, rx_ready, ardy, nack}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 mask, R2 start refused with ten-bit addressing
    clear_counts();
    wr_ctrl(16'hFFFF);
    check("R1 control mask", ctrl_rd, 16'hCF87);
    wait_cyc(10);
    check("R2 no start with bit 8 set", n_start, 0);
    wr_ctrl(MST | STT);
    wait_cyc(10);
    check("R2 no start without enable", n_start, 0);
    wr_ctrl(EN | STT);
    wait_cyc(10);
    check("R2 no start without master", n_start, 0);

    // R11: buffer event while the bus is free
    add_bytes(2, 0, 1'b1);
    wait_cyc(10);
    check("R11 event ignored while free", n_pop, 0);
    check("R11 no request while free", eng_req, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] mode;
      mode = (VECS[v].trx ? TRX : 16'h0) | (VECS[v].rm ? RM : 16'h0) | (VECS[v].stp ? STP : 16'h0);
      setup(mode, VECS[v].cnt, VECS[v].tx, VECS[v].rxp, VECS[v].nk);
      $display("vector %0d", v);
      check("R3 R4 R5 R6 R8 remaining count", count_rd, VECS[v].e_cnt);
      check("R4 R8 R9 bytes sent", n_pop, VECS[v].e_sent);
      check("R5 R8 bytes received", n_push, VECS[v].e_recv);
      check("R6 R8 stops issued", n_stop, VECS[v].e_stops);
      check("R7 access-ready pulses", n_ardy, VECS[v].e_ardy);
      check("R3 R9 no-ack pulses", n_nack, VECS[v].e_nack);
      check("R6 R9 stop bit", ctrl_rd[1], VECS[v].e_stp);
      check("R7 master bit", ctrl_rd[10], VECS[v].e_mst);
      check("R2 start bit self-clears", ctrl_rd[0], 0);
      check("R3 R6 bus busy", bus_busy, VECS[v].e_busy);
      check("R4 R8 R9 transmit-ready", tx_ready, VECS[v].e_txr);
      check("R5 R8 receive-ready", rx_ready, VECS[v].e_rxr);
      check("R6 transmit level", tx_level, VECS[v].e_txl);
    end

    // R11: refill resumes a paused counted transmit, then the stop ends it (R6)
    setup(TRX | STP, 5, 3, 0, 0);
    clear_counts();
    add_bytes(2, 0, 1'b1);
    wait_cyc(SETTLE);
    check("R11 refill resumes sending", n_pop, 2);
    check("R6 stop after refill", n_stop, 1);
    check("R6 count reloads", count_rd, 5);
    check("R6 bus released", bus_busy, 0);

    // R10: enable clear resets a held transfer
    setup(TRX | STP, 5, 3, 0, 0);
    check("R10 precondition busy", bus_busy, 1);
    wr_ctrl(16'h0000);
    @(negedge clk);
    check("R10 bus freed", bus_busy, 0);
    check("R10 count cleared", count_rd, 0);
    check("R10 ready cleared", tx_ready, 0);

    // R12: control write in the cycle the stop bit is cleared by an address no-ack
    wr_ctrl(16'h0000);
    wr_cnt(3);
    add_bytes(3, 0, 1'b0);
    addr_nack = 1'b1;
    nack_byte = 0;
    clear_counts();
    wr_ctrl(EN | MST | TRX | STT);
    while (!(eng_req && eng_done && eng_op == 2'd0)) @(negedge clk);
    wr_ctrl(EN | MST | TRX | STP);
    wait_cyc(5);
    check("R12 stop cleared over write", ctrl_rd[1], 0);
    check("R12 written bits kept", ctrl_rd & ~16'h0003, EN | MST | TRX);
    check("R12 no-ack reported", n_nack, 1);
    addr_nack = 1'b0;

    done_flag = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule